// File: doc/BRIEF.md
# Interprocessor Doorbell Interrupt Controller

This block carries doorbell events between processors that share a chip. Each event is named by a packed 32-bit identifier: a client number and a signal number within that client. A processor rings a remote client by writing an identifier to a send register. The block then emits a one-cycle outgoing doorbell that carries the two fields.

Doorbells that arrive from remote clients set per-signal pending bits. Per-signal enable bits decide which pending signals drive one level-sensitive summary interrupt.

Software services the interrupt in a loop. It reads a receive register, which names one pending, enabled signal. It writes that same identifier to a clear register. It repeats until the receive register returns all ones. Enable, disable and clear are all done by writing an identifier, not a bitmask. A client-wide clear removes every pending signal of one client in a single write.

The register bus is a simple single-cycle bus. A write takes effect at the clock edge where it is presented. A read returns its data on the cycle after the request.

Top module: `ipc_doorbell_ctrl`

## Requirements
- R1: An identifier holds the client number in bits 31:16 and the signal number in bits 15:0.
- R2: A write to offset 0x0C with an in-range identifier drives `tx_valid` high for exactly one cycle, on the cycle after the write. `tx_client` and `tx_signal` carry the written fields.
- R3: A cycle with `rx_valid` high and in-range `rx_client`/`rx_signal` sets that signal's pending bit at the next clock edge.
- R4: A write to offset 0x14 sets the named signal's enable bit. A write to offset 0x18 clears it.
- R5: `irq` is high exactly while at least one signal is both pending and enabled.
- R6: A read of offset 0x10 returns, one cycle later on `bus_rdata`, the identifier of the pending, enabled signal with the lowest client number and, within that client, the lowest signal number. It returns 0xFFFFFFFF when no signal is pending and enabled.
- R7: A write to offset 0x1C clears the named signal's pending bit. A read issued in the following cycle already reflects the clear.
- R8: A write to offset 0x38 clears, in one cycle, every pending bit of the client named in bits 31:16.
- R9: A write whose client field is out of range, or whose signal field is out of range, changes no state. This includes writes to the client-clear register whose client field is out of range. Such a write to offset 0x0C emits no doorbell. Out-of-range incoming doorbells are also ignored.
- R10: When an incoming doorbell and a clear target the same signal in the same cycle, the pending bit ends set.
- R11: Reset clears every pending bit, every enable bit, `bus_rdata`, `tx_valid` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data (an identifier) |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Incoming doorbell strobe |
| rx_client | input | 16 | Client number of the incoming doorbell |
| rx_signal | input | 16 | Signal number of the incoming doorbell |
| tx_valid | output | 1 | One-cycle outgoing doorbell strobe |
| tx_client | output | 16 | Client number of the outgoing doorbell |
| tx_signal | output | 16 | Signal number of the outgoing doorbell |
| irq | output | 1 | Level summary interrupt |

## Verification
The bench targets priority order. Several pending signals spread over different clients must come out lowest client first. A design that scanned the wrong way would hand software a higher client first.

It targets range checking. Signal number 8 of client 0 would alias onto client 1 signal 0 in a design that folded the fields without checking them. A bad enable, clear or send would then disturb a live signal, or emit a stray doorbell.

It targets a clear that collides with an arriving doorbell on the same signal, where a clear-wins design would lose the event. It also targets a reset that must drop enables, so that a later doorbell does not raise the interrupt.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam logic [7:0] OFF_SEND = 8'h0C;
    localparam logic [7:0] OFF_RECV = 8'h10;
    localparam logic [7:0] OFF_ENA  = 8'h14;
    localparam logic [7:0] OFF_DIS  = 8'h18;
    localparam logic [7:0] OFF_CLR  = 8'h1C;
    localparam logic [7:0] OFF_CCLR = 8'h38;
    localparam logic [31:0] ID_NONE = 32'hFFFF_FFFF;
endpackage

// File: rtl/ipc_wr_decode.sv
// Turns one bus write into per-signal strobe vectors; out-of-range ids give nothing.
module ipc_wr_decode #(
    parameter int NC = 4,
    parameter int NS = 8,
    localparam int NT = NC * NS
) (
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [31:0]   wdata,
    output logic [NT-1:0] ena_vec,
    output logic [NT-1:0] dis_vec,
    output logic [NT-1:0] clr_vec,
    output logic [NT-1:0] cclr_vec,
    output logic          send_fire
);
    import ipc_pkg::*;

    logic [15:0]   fld_c, fld_s;
    logic          id_ok, cli_ok;
    logic [NT-1:0] hit_vec, cli_vec;

    assign fld_c  = wdata[31:16];
    assign fld_s  = wdata[15:0];
    assign id_ok  = (int'(fld_c) < NC) && (int'(fld_s) < NS);
    assign cli_ok = int'(fld_c) < NC;

    for (genvar c = 0; c < NC; c++) begin : g_cli
        for (genvar s = 0; s < NS; s++) begin : g_sig
            assign hit_vec[c*NS+s] = id_ok && (int'(fld_c) == c) && (int'(fld_s) == s);
            assign cli_vec[c*NS+s] = cli_ok && (int'(fld_c) == c);
        end
    end

    always_comb begin
        ena_vec   = '0;
        dis_vec   = '0;
        clr_vec   = '0;
        cclr_vec  = '0;
        send_fire = 1'b0;
        if (wr_en) begin
            unique case (addr)
                OFF_ENA:  ena_vec   = hit_vec;
                OFF_DIS:  dis_vec   = hit_vec;
                OFF_CLR:  clr_vec   = hit_vec;
                OFF_CCLR: cclr_vec  = cli_vec;
                OFF_SEND: send_fire = id_ok;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ipc_pick.sv
// Fixed-priority pick: lowest client, then lowest signal.
module ipc_pick #(
    parameter int NC = 4,
    parameter int NS = 8,
    localparam int NT = NC * NS,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0] act,
    output logic          found,
    output logic [IW-1:0] pick_idx,
    output logic [31:0]   pick_id
);
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        pick_id  = '0;
        for (int c = NC - 1; c >= 0; c--) begin
            for (int s = NS - 1; s >= 0; s--) begin
                if (act[c*NS+s]) begin
                    found    = 1'b1;
                    pick_idx = IW'(c * NS + s);
                    pick_id  = {16'(c), 16'(s)};
                end
            end
        end
    end
endmodule

// File: rtl/ipc_doorbell_ctrl.sv
module ipc_doorbell_ctrl #(
    parameter int NC = 4,
    parameter int NS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [15:0] rx_client,
    input  logic [15:0] rx_signal,
    output logic        tx_valid,
    output logic [15:0] tx_client,
    output logic [15:0] tx_signal,
    output logic        irq
);
    import ipc_pkg::*;

    localparam int NT = NC * NS;
    localparam int IW = (NT > 1) ? $clog2(NT) : 1;

    typedef struct packed {
        logic [NT-1:0] pend;
        logic [NT-1:0] ena;
        logic [31:0]   rdata;
        logic          tx_v;
        logic [15:0]   tx_c;
        logic [15:0]   tx_s;
    } st_t;

    st_t st_d, st_q;

    logic [NT-1:0] ena_vec, dis_vec, clr_vec, cclr_vec, rx_vec, act;
    logic          send_fire, pick_found, rd_recv;
    logic [IW-1:0] pick_idx;
    logic [31:0]   pick_id;

    ipc_wr_decode #(.NC(NC), .NS(NS)) u_dec (
        .wr_en    (bus_sel && bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ena_vec  (ena_vec),
        .dis_vec  (dis_vec),
        .clr_vec  (clr_vec),
        .cclr_vec (cclr_vec),
        .send_fire(send_fire)
    );

    for (genvar c = 0; c < NC; c++) begin : g_rc
        for (genvar s = 0; s < NS; s++) begin : g_rs
            assign rx_vec[c*NS+s] = rx_valid && (int'(rx_client) == c) && (int'(rx_signal) == s);
        end
    end

    assign act = st_q.pend & st_q.ena;

    ipc_pick #(.NC(NC), .NS(NS)) u_pick (
        .act     (act),
        .found   (pick_found),
        .pick_idx(pick_idx),
        .pick_id (pick_id)
    );

    assign rd_recv = bus_sel && !bus_we && (bus_addr == OFF_RECV);

    always_comb begin
        st_d      = st_q;
        // incoming doorbell applied after clears so the set wins
        st_d.pend = (st_q.pend & ~clr_vec & ~cclr_vec) | rx_vec;
        st_d.ena  = (st_q.ena | ena_vec) & ~dis_vec;
        st_d.tx_v = send_fire;
        if (send_fire) begin
            st_d.tx_c = bus_wdata[31:16];
            st_d.tx_s = bus_wdata[15:0];
        end
        if (bus_sel && !bus_we) begin
            st_d.rdata = rd_recv ? (pick_found ? pick_id : ID_NONE) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign tx_valid  = st_q.tx_v;
    assign tx_client = st_q.tx_c;
    assign tx_signal = st_q.tx_s;
    assign irq       = |act;

    // R2
    send_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_fire |=> (tx_valid && tx_client == $past(bus_wdata[31:16])
                       && tx_signal == $past(bus_wdata[15:0])));
    // R2
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !send_fire |=> !tx_valid);
    // R3
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vec != '0) |=> ((st_q.pend & $past(rx_vec)) == $past(rx_vec)));
    // R7
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0 && rx_vec == '0) |=> ((st_q.pend & $past(clr_vec)) == '0));
    // R6
    recv_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_recv && act == '0) |=> (bus_rdata == ID_NONE));
    // R6
    pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> act[pick_idx]);
endmodule

// File: tb/sim_ipc_doorbell_ctrl.sv
`timescale 1ns/1ps
module sim_ipc_doorbell_ctrl;
    localparam int NC = 4;
    localparam int NS = 8;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        rx_valid = 0;
    logic [15:0] rx_client = 0, rx_signal = 0;
    logic        tx_valid, irq;
    logic [15:0] tx_client, tx_signal;

    always #2 clk = ~clk;

    ipc_doorbell_ctrl #(.NC(NC), .NS(NS)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    logic [NC*NS-1:0] pend_m = '0, ena_m = '0;
    logic [31:0] rd_q[$];
    logic [31:0] tx_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_pick();
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                if (pend_m[c*NS+s] && ena_m[c*NS+s]) return {16'(c), 16'(s)};
        return 32'hFFFF_FFFF;
    endfunction

    // driver: one bus op plus optional incoming doorbell in one cycle
    task automatic cyc(logic sel, logic we, logic [7:0] a, logic [31:0] d,
                       logic rv, logic [15:0] rc, logic [15:0] rs);
        int c, s; bit ok, cok;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_client = rc; rx_signal = rs;
        c = int'(d[31:16]); s = int'(d[15:0]);
        ok = (c < NC) && (s < NS); cok = c < NC;
        if (sel && !we && a == 8'h10) rd_q.push_back(model_pick());
        if (sel && we) begin
            case (a)
                8'h0C: if (ok) tx_q.push_back(d);
                8'h14: if (ok) ena_m[c*NS+s] = 1'b1;
                8'h18: if (ok) ena_m[c*NS+s] = 1'b0;
                8'h1C: if (ok) pend_m[c*NS+s] = 1'b0;
                8'h38: if (cok) for (int k = 0; k < NS; k++) pend_m[c*NS+k] = 1'b0;
                default: ;
            endcase
        end
        if (rv && int'(rc) < NC && int'(rs) < NS) pend_m[int'(rc)*NS+int'(rs)] = 1'b1;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; rx_valid = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d); cyc(1, 1, a, d, 0, 0, 0); endtask
    task automatic rd(); cyc(1, 0, 8'h10, 0, 0, 0, 0); endtask
    task automatic ring(int c, int s); cyc(0, 0, 0, 0, 1, 16'(c), 16'(s)); endtask

    // monitor: read data and outgoing doorbells
    always @(posedge clk) begin
        logic was_rd;
        was_rd = bus_sel && !bus_we && bus_addr == 8'h10;
        #1;
        if (was_rd) begin
            if (rd_q.size() == 0) chk("R6 read queue", 32'h1, 32'h0);
            else chk("R6 R1 recv id", bus_rdata, rd_q.pop_front());
        end
        if (tx_valid) begin
            if (tx_q.size() == 0) chk("R2 R9 stray tx", {tx_client, tx_signal}, 32'hDEAD_DEAD);
            else chk("R2 tx fields", {tx_client, tx_signal}, tx_q.pop_front());
        end
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 rdata", bus_rdata, 0);
        chk("R11 irq", {31'b0, irq}, 0);
        chk("R11 tx", {31'b0, tx_valid}, 0);
        rst_n = 1;
        rd();                                   // R6 empty -> all ones
        ring(1, 3);
        chk("R5 irq off while disabled", {31'b0, irq}, 0);
        rd();
        wr(8'h14, 32'h0001_0003);               // R4 enable
        chk("R5 irq on", {31'b0, irq}, 1);
        rd();                                   // R1 id 0x00010003
        ring(0, 5); wr(8'h14, 32'h0000_0005);
        ring(2, 0); wr(8'h14, 32'h0002_0000);
        rd();                                   // R6 lowest client first
        wr(8'h1C, 32'h0000_0005); rd();         // R7 clear then next
        wr(8'h1C, 32'h0001_0003); rd();
        ring(2, 1); ring(2, 7); wr(8'h14, 32'h0002_0007);
        wr(8'h38, 32'h0002_0000);               // R8 client clear
        chk("R8 irq after client clear", {31'b0, irq}, 0);
        rd();
        ring(3, 4); wr(8'h14, 32'h0003_0004);
        chk("R4 irq enabled", {31'b0, irq}, 1);
        wr(8'h18, 32'h0003_0004);
        chk("R4 irq after disable", {31'b0, irq}, 0);
        rd();
        // R9 out-of-range writes must not alias onto client 1 signal 0
        ring(1, 0);
        wr(8'h14, 32'h0000_0008);
        wr(8'h14, 32'h0004_0000);
        chk("R9 irq after bad enable", {31'b0, irq}, 0);
        wr(8'h14, 32'h0001_0000);
        wr(8'h1C, 32'h0000_0008);
        wr(8'h38, 32'h0005_0000);
        ring(4, 0); ring(0, 9);
        rd();                                   // still 0x00010000
        wr(8'h0C, 32'h0000_0008);               // no doorbell
        wr(8'h0C, 32'h0003_0007);               // R2 back-to-back sends
        wr(8'h0C, 32'h0000_0000);
        // R10 doorbell and clear on same signal
        cyc(1, 1, 8'h1C, 32'h0001_0000, 1, 16'd1, 16'd0);
        rd();
        chk("R10 irq kept", {31'b0, irq}, 1);
        wr(8'h1C, 32'h0001_0000); rd();
        // R11 reset drops enables
        wr(8'h14, 32'h0000_0001);
        @(negedge clk); rst_n = 0; pend_m = '0; ena_m = '0;
        @(negedge clk); rst_n = 1;
        ring(0, 1);
        chk("R11 enable cleared", {31'b0, irq}, 0);
        rd();
        repeat (3) @(negedge clk);
        chk("R2 all sends seen", tx_q.size(), 0);
        chk("R6 all reads seen", rd_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule